// File: doc/BRIEF.md
# Conditional Scratch Swap Register Unit

This unit holds the machine and supervisor scratch registers and implements a conditional-swap view of each one. A handler issues a single write-style register access to the swap view at entry and again at exit. The scratch value and the operand are exchanged only if the trap came from a different privilege mode than the one that handles it. If the trap came from the same mode, the operand is returned unchanged and the scratch register is left alone. Nested handlers in one mode therefore keep their stack pointer, and a handler entered from a lower mode picks up its own stack.

The core presents the current privilege, the previous-privilege fields of the machine and supervisor status registers, the operand, the operation kind and a one-cycle strobe. The unit answers in the same cycle with the read value and an illegal-access flag. The chosen scratch register updates on the next rising clock edge. Raising the exception is left to the core. A build parameter removes the supervisor view for harts that have no supervisor mode. With no supervisor mode, the least privileged mode with a swap view is machine.

Top module: `scratch_swap_csr`

## Requirements
- R1: Machine view (`sel_i`=0) written in machine mode with machine previous privilege (`mpp_i`=2'b11): `rdata_o` equals `wdata_i`, and the machine scratch does not change.
- R2: Machine view written in machine mode with `mpp_i` not 2'b11: `rdata_o` is the old machine scratch, and after the next edge the machine scratch holds `wdata_i`.
- R3: Supervisor view (`sel_i`=1) written in supervisor mode (`priv_i`=2'b01) with `spp_i`=1: `rdata_o` equals `wdata_i`, and the supervisor scratch does not change.
- R4: Supervisor view written in supervisor mode with `spp_i`=0: `rdata_o` is the old supervisor scratch, and after the next edge the supervisor scratch holds `wdata_i`.
- R5: Supervisor view written in machine mode (`priv_i`=2'b11). It swaps when `mpp_i` is 2'b01 or 2'b00. It echoes the operand without a swap when `mpp_i` is 2'b11.
- R6: An access to a view from a less privileged mode (machine view from 2'b01 or 2'b00, supervisor view from 2'b00) raises `illegal_o`, returns `rdata_o`=0 and changes no scratch register.
- R7: Only `op_i`=2'b01 (write) is legal. Read (2'b00), set (2'b10) and clear (2'b11) raise `illegal_o`, return 0 and change no scratch register.
- R8: During and right after reset, both scratch registers read zero.
- R9: With `req_i` low, `rdata_o` and `illegal_o` are 0 and no scratch register changes.
- R10: With `SUPV_EN`=0, every supervisor-view access is illegal and `sscratch_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| sel_i | input | 1 | View select: 0 machine, 1 supervisor |
| op_i | input | 2 | Access kind: 00 read, 01 write, 10 set, 11 clear |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| mpp_i | input | 2 | Machine previous-privilege field |
| spp_i | input | 1 | Supervisor previous-privilege bit |
| wdata_i | input | DATA_W | Write operand |
| rdata_o | output | DATA_W | Value returned to the destination register |
| illegal_o | output | 1 | Access must trap |
| mscratch_o | output | DATA_W | Machine scratch register |
| sscratch_o | output | DATA_W | Supervisor scratch register |

## Verification
The assertions check every cycle that a lower-privilege access is flagged, that illegal and idle cycles leave both registers stable, and that the echo and swap cases of the machine view return the right value and update the register as required. Some behaviours appear only in the bench scenarios. These are the three-way decision for the supervisor view, which depends on both the current mode and the previous-privilege fields. They also include the return of the old value across long chains of back-to-back swaps, and the variant built without a supervisor view. A cycle-by-cycle model in the bench covers all of these.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef enum logic {
    SEL_M = 1'b0,
    SEL_S = 1'b1
  } view_sel_e;

  typedef struct packed {
    logic illegal;
    logic swap;
    logic echo;
  } swap_dec_t;
endpackage

// File: rtl/scs_swap_decode.sv
module scs_swap_decode
  import scs_pkg::*;
#(
  parameter bit SUPV_EN = 1'b1
) (
  input  logic      req_i,
  input  logic      sel_i,
  input  logic [1:0] op_i,
  input  logic [1:0] priv_i,
  input  logic [1:0] mpp_i,
  input  logic      spp_i,
  output swap_dec_t dec_o
);
  priv_e   cur_priv;
  priv_e   m_prev;
  csr_op_e op_kind;
  logic    priv_ok;
  logic    op_ok;
  logic    from_other;

  assign cur_priv = priv_e'(priv_i);
  assign m_prev   = priv_e'(mpp_i);
  assign op_kind  = csr_op_e'(op_i);
  assign op_ok    = (op_kind == OP_WRITE);

  always_comb begin
    priv_ok    = 1'b0;
    from_other = 1'b0;
    if (view_sel_e'(sel_i) == SEL_M) begin
      priv_ok    = (cur_priv == PRIV_M);
      from_other = (m_prev != PRIV_M);
    end else begin
      priv_ok = SUPV_EN && ((cur_priv == PRIV_M) || (cur_priv == PRIV_S));
      // machine-mode access consults the machine previous-privilege field
      if (cur_priv == PRIV_M) from_other = (m_prev != PRIV_M);
      else                    from_other = !spp_i;
    end
  end

  always_comb begin
    dec_o.illegal = req_i && !(priv_ok && op_ok);
    dec_o.swap    = req_i && priv_ok && op_ok && from_other;
    dec_o.echo    = req_i && priv_ok && op_ok && !from_other;
  end
endmodule

// File: rtl/scs_scratch_reg.sv
module scs_scratch_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/scratch_swap_csr.sv
module scratch_swap_csr
  import scs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit SUPV_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              sel_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        priv_i,
  input  logic [1:0]        mpp_i,
  input  logic              spp_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] mscratch_o,
  output logic [DATA_W-1:0] sscratch_o
);
  localparam logic [DATA_W-1:0] ZERO = '0;

  swap_dec_t         dec;
  logic              we_m;
  logic              we_s;
  logic [DATA_W-1:0] old_val;

  scs_swap_decode #(.SUPV_EN(SUPV_EN)) u_dec (
    .req_i  (req_i),
    .sel_i  (sel_i),
    .op_i   (op_i),
    .priv_i (priv_i),
    .mpp_i  (mpp_i),
    .spp_i  (spp_i),
    .dec_o  (dec)
  );

  assign we_m = dec.swap && (view_sel_e'(sel_i) == SEL_M);
  assign we_s = dec.swap && (view_sel_e'(sel_i) == SEL_S);

  scs_scratch_reg #(.DATA_W(DATA_W)) u_mreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_m),
    .d_i    (wdata_i),
    .q_o    (mscratch_o)
  );

  generate
    if (SUPV_EN) begin : g_supv
      scs_scratch_reg #(.DATA_W(DATA_W)) u_sreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (we_s),
        .d_i    (wdata_i),
        .q_o    (sscratch_o)
      );
    end else begin : g_no_supv
      assign sscratch_o = ZERO;
    end
  endgenerate

  assign old_val = (view_sel_e'(sel_i) == SEL_M) ? mscratch_o : sscratch_o;

  always_comb begin
    if (dec.swap)      rdata_o = old_val;
    else if (dec.echo) rdata_o = wdata_i;
    else               rdata_o = ZERO;
  end
  assign illegal_o = dec.illegal;

  // R6: lower-privileged access to the machine view
  assert_lower_priv_trap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !sel_i && priv_i != 2'b11) |-> illegal_o);

  // R1
  assert_m_echo_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !sel_i && op_i == 2'b01 && priv_i == 2'b11 && mpp_i == 2'b11)
      |-> (rdata_o == wdata_i) ##1 $stable(mscratch_o));

  // R2
  assert_m_swap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !sel_i && op_i == 2'b01 && priv_i == 2'b11 && mpp_i != 2'b11)
      |=> (mscratch_o == $past(wdata_i)) && ($past(rdata_o) == $past(mscratch_o)));

  // R6, R7: a trapping access leaves both registers alone
  assert_illegal_no_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(mscratch_o) && $stable(sscratch_o));

  // R9
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == ZERO) && !illegal_o ##1 $stable(mscratch_o) && $stable(sscratch_o));

  // R8
  assert_reset_zero_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (mscratch_o == ZERO) && (sscratch_o == ZERO));
endmodule

// File: tb/scratch_swap_csr_bench.sv
module scratch_swap_csr_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic         sel = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [1:0]   priv = 2'b11;
  logic [1:0]   mpp = 2'b11;
  logic         spp = 1'b0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] rdata, msc, ssc;
  logic         ill;
  logic [W-1:0] rdata_n, msc_n, ssc_n;
  logic         ill_n;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] m_ref = '0;
  logic [W-1:0] s_ref = '0;
  string        last_tag = "R8";

  always #10 clk = ~clk;

  scratch_swap_csr #(.DATA_W(W), .SUPV_EN(1'b1)) u_scratch_swap_csr (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sel_i(sel), .op_i(op),
    .priv_i(priv), .mpp_i(mpp), .spp_i(spp), .wdata_i(wd),
    .rdata_o(rdata), .illegal_o(ill), .mscratch_o(msc), .sscratch_o(ssc)
  );

  scratch_swap_csr #(.DATA_W(W), .SUPV_EN(1'b0)) u_scratch_swap_csr_nosupv (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sel_i(sel), .op_i(op),
    .priv_i(priv), .mpp_i(mpp), .spp_i(spp), .wdata_i(wd),
    .rdata_o(rdata_n), .illegal_o(ill_n), .mscratch_o(msc_n), .sscratch_o(ssc_n)
  );

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one access per clock; checks mid-cycle, model updates at the edge
  task automatic cyc(input logic r, input logic s, input logic [1:0] o, input logic [1:0] p,
                     input logic [1:0] mp, input logic sp, input logic [W-1:0] d);
    int    cur_lvl, need_lvl;
    bit    legal, do_swap;
    string tag;
    logic [W-1:0] exp_rd;
    @(negedge clk);
    req = r; sel = s; op = o; priv = p; mpp = mp; spp = sp; wd = d;
    #2;
    chk(last_tag, "mscratch", msc, m_ref);
    chk(last_tag, "sscratch", ssc, s_ref);
    cur_lvl  = int'(p);
    need_lvl = s ? 1 : 3;
    legal    = r && (o == 2'b01) && (cur_lvl >= need_lvl) && (p != 2'b10);
    if (!s)            do_swap = (mp != 2'b11);
    else if (p == 2'b11) do_swap = (mp != 2'b11);
    else               do_swap = !sp;
    if (!r)                       tag = "R9";
    else if (o != 2'b01)          tag = "R7";
    else if (!legal)              tag = "R6";
    else if (!s)                  tag = do_swap ? "R2" : "R1";
    else if (p == 2'b11)          tag = "R5";
    else                          tag = do_swap ? "R4" : "R3";
    if (!legal)       exp_rd = '0;
    else if (do_swap) exp_rd = s ? s_ref : m_ref;
    else              exp_rd = d;
    chk(tag, "rdata", rdata, exp_rd);
    chk(tag, "illegal", {{(W-1){1'b0}}, ill}, {{(W-1){1'b0}}, (r && !legal)});
    if (r && s) begin
      chk("R10", "illegal_nosupv", {{(W-1){1'b0}}, ill_n}, {{(W-1){1'b0}}, 1'b1});
      chk("R10", "sscratch_nosupv", ssc_n, '0);
    end
    @(posedge clk);
    if (legal && do_swap) begin
      if (s) s_ref = d; else m_ref = d;
    end
    last_tag = tag;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #35;
    chk("R8", "mscratch_in_reset", msc, '0);
    chk("R8", "sscratch_in_reset", ssc, '0);
    @(negedge clk); rst_n = 1'b1;
    // directed
    cyc(1'b0, 1'b0, 2'b01, 2'b11, 2'b11, 1'b0, 32'hdead0000);          // R9 idle
    cyc(1'b1, 1'b0, 2'b01, 2'b11, 2'b00, 1'b0, 32'h1111_0001);         // R2 U->M
    cyc(1'b1, 1'b0, 2'b01, 2'b11, 2'b11, 1'b0, 32'h2222_0002);         // R1 nested
    cyc(1'b1, 1'b0, 2'b01, 2'b11, 2'b01, 1'b0, 32'h3333_0003);         // R2 S->M
    cyc(1'b1, 1'b1, 2'b01, 2'b01, 2'b11, 1'b0, 32'h4444_0004);         // R4
    cyc(1'b1, 1'b1, 2'b01, 2'b01, 2'b11, 1'b1, 32'h5555_0005);         // R3
    cyc(1'b1, 1'b1, 2'b01, 2'b11, 2'b01, 1'b1, 32'h6666_0006);         // R5 swap
    cyc(1'b1, 1'b1, 2'b01, 2'b11, 2'b00, 1'b1, 32'h7777_0007);         // R5 swap
    cyc(1'b1, 1'b1, 2'b01, 2'b11, 2'b11, 1'b0, 32'h8888_0008);         // R5 echo
    cyc(1'b1, 1'b0, 2'b01, 2'b01, 2'b00, 1'b0, 32'h9999_0009);         // R6
    cyc(1'b1, 1'b0, 2'b01, 2'b00, 2'b00, 1'b0, 32'haaaa_000a);         // R6
    cyc(1'b1, 1'b1, 2'b01, 2'b00, 2'b00, 1'b0, 32'hbbbb_000b);         // R6
    cyc(1'b1, 1'b0, 2'b00, 2'b11, 2'b00, 1'b0, 32'hcccc_000c);         // R7 read
    cyc(1'b1, 1'b0, 2'b10, 2'b11, 2'b00, 1'b0, 32'hdddd_000d);         // R7 set
    cyc(1'b1, 1'b1, 2'b11, 2'b01, 2'b00, 1'b0, 32'heeee_000e);         // R7 clear
    cyc(1'b0, 1'b1, 2'b01, 2'b01, 2'b00, 1'b0, 32'hffff_000f);         // R9
    // random traffic over legal privilege encodings
    for (int i = 0; i < 600; i++) begin
      logic [1:0] pr, mp;
      int k;
      k  = $urandom_range(0, 2);
      pr = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b11;
      k  = $urandom_range(0, 2);
      mp = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b11;
      cyc(($urandom_range(0, 7) != 0), 1'($urandom), ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b01,
          pr, mp, 1'($urandom), $urandom);
    end
    cyc(1'b0, 1'b0, 2'b00, 2'b11, 2'b11, 1'b0, '0);
    // reset mid-run
    @(negedge clk); rst_n = 1'b0; m_ref = '0; s_ref = '0;
    #2;
    chk("R8", "mscratch_after_reset", msc, '0);
    chk("R8", "sscratch_after_reset", ssc, '0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule